// File: doc/BRIEF.md
# Pin-Override General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port with per-pin hand-over to on-chip peripherals. Software owns two registers: a direction register (1 = output) and a port register, which holds the output level for an output pin and the pull-up request for an input pin. A third readable register returns the pad levels after a two-flop synchronizer. All three are reached over a small synchronous bus.

Peripherals take pins through fixed rules. A serial transmitter drives its pin as an output. A serial receiver forces its pin to be an input but leaves the pull-up to the port bit. Two timer compare outputs replace the output level only when software has already made the pin an output. A divided system clock, when its configuration input is high, claims its pin completely, even while reset is held. Peripherals appear here only as enable and data inputs. The pin numbers and the clock-output option are parameters.

Top module: `gpio_port_ovr`

## Requirements
- R1: While reset is held and after it, the direction and port registers read 0, and every pin has pad_oe=0, pad_out=0 and pad_pu=0. The one exception is the clock-output pin when clkout_cfg is 1.
- R2: Register addresses are 0 = synchronized pin levels (read only), 1 = direction, 2 = port, 3 = unused (reads 0). A write on a rising edge with bus_we=1 updates the addressed register. bus_rdata follows bus_addr combinationally. Direction and port reads return the written values, never the overridden pad state. Writes to addresses 0 and 3 change nothing.
- R3: A pad level applied just after a rising edge shows in register 0 after the second following rising edge and not after the first.
- R4: For a pin with no override, pad_oe equals its direction bit and pad_out equals its port bit when pad_oe is 1. pad_out is 0 whenever pad_oe is 0.
- R5: pad_pu is 1 exactly when the pin's final pad_oe is 0, its port bit is 1 and pullup_dis is 0. Any override that makes a pin an output turns its pull-up off.
- R6: With tx_en=1, the transmit pin (default 3) has pad_oe=1 and pad_out=tx_data, whatever its direction bit.
- R7: With rx_en=1, the receive pin (default 2) has pad_oe=0, whatever its direction bit.
- R8: While rx_en forces the receive pin to input, its pull-up still follows its port bit and pullup_dis, as in R5.
- R9: Compare output A (pin 1) and compare output B (pin 0) set pad_out to their data only when their enable is 1 and the pin's direction bit is 1. Otherwise the pin behaves as in R4.
- R10: With clkout_cfg=1, the clock pin (default 0) has pad_oe=1 and pad_out=clk_div, ignoring its direction and port bits. This also holds during reset.
- R11: When the clock output and compare output B share a pin and both are active, the clock output wins.
- R12: Writing 0 to a pin's direction and port bits leaves it with pad_oe=0 and pad_pu=0. This is the state an analog input pin needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |
| pullup_dis | input | 1 | Global pull-up disable |
| tx_en | input | 1 | Serial transmitter enable |
| tx_data | input | 1 | Serial transmit data |
| rx_en | input | 1 | Serial receiver enable |
| cmpa_en | input | 1 | Timer compare output A enable |
| cmpa_data | input | 1 | Timer compare output A level |
| cmpb_en | input | 1 | Timer compare output B enable |
| cmpb_data | input | 1 | Timer compare output B level |
| clkout_cfg | input | 1 | Clock-output configuration |
| clk_div | input | 1 | Divided system clock |

## Verification
The bench uses the default parameters: eight pins, two synchronizer stages and the clock output enabled. With these values the transmitter, receiver and compare A pins are all different, while compare B and the clock output share pin 0. At eight bits the bench can sweep all 256 direction values. Because pin 0 is shared, every combination of the ten peripheral control inputs over four register patterns also drives the clock-versus-compare priority case.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

   localparam int BUS_AW = 2;

   typedef enum logic [BUS_AW-1:0] {
      RSEL_PIN  = 2'd0,
      RSEL_DIR  = 2'd1,
      RSEL_PORT = 2'd2,
      RSEL_NONE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic dir_en;
      logic dir_val;
      logic lvl_en;
      logic lvl_val;
   } pin_ovr_t;

   localparam pin_ovr_t OVR_NONE = '{dir_en: 1'b0, dir_val: 1'b0, lvl_en: 1'b0, lvl_val: 1'b0};

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_ovr_map.sv
module gpio_ovr_map
   import gpio_ovr_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter int TX_PIN   = 3,
   parameter int RX_PIN   = 2,
   parameter int CMPA_PIN = 1,
   parameter int CMPB_PIN = 0,
   parameter int CLK_PIN  = 0
) (
   input  logic [WIDTH-1:0] dir_q,
   input  logic             tx_en,
   input  logic             tx_data,
   input  logic             rx_en,
   input  logic             cmpa_en,
   input  logic             cmpa_data,
   input  logic             cmpb_en,
   input  logic             cmpb_data,
   input  logic             ck_req,
   input  logic             clk_div,
   output pin_ovr_t         ovr [WIDTH]
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      localparam bit IS_TX   = (i == TX_PIN);
      localparam bit IS_RX   = (i == RX_PIN);
      localparam bit IS_CMPA = (i == CMPA_PIN);
      localparam bit IS_CMPB = (i == CMPB_PIN);
      localparam bit IS_CLK  = (i == CLK_PIN);

      // lowest priority first; later claims overwrite earlier ones
      always_comb begin
         ovr[i] = OVR_NONE;
         if (IS_CMPB && cmpb_en && dir_q[i]) begin
            ovr[i].lvl_en  = 1'b1;
            ovr[i].lvl_val = cmpb_data;
         end
         if (IS_CMPA && cmpa_en && dir_q[i]) begin
            ovr[i].lvl_en  = 1'b1;
            ovr[i].lvl_val = cmpa_data;
         end
         if (IS_RX && rx_en) begin
            ovr[i].dir_en  = 1'b1;
            ovr[i].dir_val = 1'b0;
         end
         if (IS_TX && tx_en) begin
            ovr[i].dir_en  = 1'b1;
            ovr[i].dir_val = 1'b1;
            ovr[i].lvl_en  = 1'b1;
            ovr[i].lvl_val = tx_data;
         end
         if (IS_CLK && ck_req) begin
            ovr[i].dir_en  = 1'b1;
            ovr[i].dir_val = 1'b1;
            ovr[i].lvl_en  = 1'b1;
            ovr[i].lvl_val = clk_div;
         end
      end
   end

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
   import gpio_ovr_pkg::*;
(
   input  logic     dir_bit,
   input  logic     port_bit,
   input  logic     pu_block,
   input  pin_ovr_t ovr,
   output logic     oe,
   output logic     out,
   output logic     pu
);

   logic oe_eff;
   logic lvl_eff;

   always_comb begin
      oe_eff  = ovr.dir_en ? ovr.dir_val : dir_bit;
      lvl_eff = ovr.lvl_en ? ovr.lvl_val : port_bit;
      oe      = oe_eff;
      out     = oe_eff & lvl_eff;
      pu      = ~oe_eff & port_bit & ~pu_block;
   end

endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
   import gpio_ovr_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int TX_PIN      = 3,
   parameter int RX_PIN      = 2,
   parameter int CMPA_PIN    = 1,
   parameter int CMPB_PIN    = 0,
   parameter int CLK_PIN     = 0,
   parameter bit CLKOUT_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_addr,
   input  logic             bus_we,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_pu,
   input  logic             pullup_dis,
   input  logic             tx_en,
   input  logic             tx_data,
   input  logic             rx_en,
   input  logic             cmpa_en,
   input  logic             cmpa_data,
   input  logic             cmpb_en,
   input  logic             cmpb_data,
   input  logic             clkout_cfg,
   input  logic             clk_div
);

   // elaboration checks
   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("gpio_port_ovr: WIDTH out of range");
   end
   if (TX_PIN >= WIDTH || RX_PIN >= WIDTH || CMPA_PIN >= WIDTH ||
       CMPB_PIN >= WIDTH || CLK_PIN >= WIDTH) begin : g_bad_pin
      $error("gpio_port_ovr: peripheral pin index beyond WIDTH");
   end
   if (TX_PIN == RX_PIN) begin : g_bad_serial
      $error("gpio_port_ovr: transmit and receive pins must differ");
   end

   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] port_q;
   logic [WIDTH-1:0] pin_sync;
   logic             ck_req;
   pin_ovr_t         ovr [WIDTH];
   reg_sel_e         sel;

   assign sel = reg_sel_e'(bus_addr);

   // register file
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         port_q <= '0;
      end else if (bus_we) begin
         case (sel)
            RSEL_DIR:  dir_q  <= bus_wdata;
            RSEL_PORT: port_q <= bus_wdata;
            default:   ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         RSEL_PIN:  bus_rdata = pin_sync;
         RSEL_DIR:  bus_rdata = dir_q;
         RSEL_PORT: bus_rdata = port_q;
         default:   bus_rdata = '0;
      endcase
   end

   // clock-output option
   if (CLKOUT_EN) begin : g_ck
      assign ck_req = clkout_cfg;
   end else begin : g_no_ck
      assign ck_req = 1'b0;
   end

   gpio_in_sync #(
      .WIDTH  (WIDTH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_sync)
   );

   gpio_ovr_map #(
      .WIDTH    (WIDTH),
      .TX_PIN   (TX_PIN),
      .RX_PIN   (RX_PIN),
      .CMPA_PIN (CMPA_PIN),
      .CMPB_PIN (CMPB_PIN),
      .CLK_PIN  (CLK_PIN)
   ) u_map (
      .dir_q     (dir_q),
      .tx_en     (tx_en),
      .tx_data   (tx_data),
      .rx_en     (rx_en),
      .cmpa_en   (cmpa_en),
      .cmpa_data (cmpa_data),
      .cmpb_en   (cmpb_en),
      .cmpb_data (cmpb_data),
      .ck_req    (ck_req),
      .clk_div   (clk_div),
      .ovr       (ovr)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      gpio_pin_cell u_cell (
         .dir_bit  (dir_q[i]),
         .port_bit (port_q[i]),
         .pu_block (pullup_dis),
         .ovr      (ovr[i]),
         .oe       (pad_oe[i]),
         .out      (pad_out[i]),
         .pu       (pad_pu[i])
      );
   end

endmodule

// File: rtl/gpio_port_ovr_chk.sv
module gpio_port_ovr_chk #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int TX_PIN      = 3,
   parameter int RX_PIN      = 2,
   parameter int CMPA_PIN    = 1,
   parameter int CMPB_PIN    = 0,
   parameter int CLK_PIN     = 0,
   parameter bit CLKOUT_EN   = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] pad_in,
   input logic [WIDTH-1:0] pad_out,
   input logic [WIDTH-1:0] pad_oe,
   input logic [WIDTH-1:0] pad_pu,
   input logic [WIDTH-1:0] dir_q,
   input logic [WIDTH-1:0] port_q,
   input logic [WIDTH-1:0] pin_sync,
   input logic             pullup_dis,
   input logic             tx_en,
   input logic             tx_data,
   input logic             rx_en,
   input logic             cmpa_en,
   input logic             clkout_cfg,
   input logic             clk_div
);

   localparam bit TX_FREE   = !(CLKOUT_EN && TX_PIN == CLK_PIN);
   localparam bit RX_FREE   = !(CLKOUT_EN && RX_PIN == CLK_PIN) && RX_PIN != TX_PIN;
   localparam bit CMPA_FREE = !(CLKOUT_EN && CMPA_PIN == CLK_PIN) &&
                              CMPA_PIN != TX_PIN && CMPA_PIN != RX_PIN;

   logic [1:0] up_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) up_cnt <= '0;
      else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
   end

   p_pu_only_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_oe) == '0);

   p_pu_global_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pullup_dis |-> pad_pu == '0);

   p_out_low_when_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~pad_oe) == '0);

   p_tx_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (TX_FREE && tx_en) |-> (pad_oe[TX_PIN] && pad_out[TX_PIN] == tx_data));

   p_rx_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (RX_FREE && rx_en) |-> !pad_oe[RX_PIN]);

   p_rx_pullup_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (RX_FREE && rx_en) |-> (pad_pu[RX_PIN] == (port_q[RX_PIN] && !pullup_dis)));

   p_cmpa_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (CMPA_FREE && cmpa_en && !dir_q[CMPA_PIN]) |->
         (!pad_oe[CMPA_PIN] && pad_pu[CMPA_PIN] == (port_q[CMPA_PIN] && !pullup_dis)));

   p_clk_claim_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (CLKOUT_EN && clkout_cfg) |-> (pad_oe[CLK_PIN] && pad_out[CLK_PIN] == clk_div));

   // reset window: clocked immediate check, since properties are disabled then
   always @(posedge clk) begin
      if (!rst_n && CLKOUT_EN && clkout_cfg === 1'b1) begin
         p_clk_in_reset_r10: assert (pad_oe[CLK_PIN] === 1'b1 && pad_out[CLK_PIN] === clk_div);
      end
   end

   if (SYNC_STAGES == 2) begin : g_lag
      p_sync_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (up_cnt >= 2'd2) |-> pin_sync == $past(pad_in, 2));
   end

endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(
   .WIDTH       (WIDTH),
   .SYNC_STAGES (SYNC_STAGES),
   .TX_PIN      (TX_PIN),
   .RX_PIN      (RX_PIN),
   .CMPA_PIN    (CMPA_PIN),
   .CMPB_PIN    (CMPB_PIN),
   .CLK_PIN     (CLK_PIN),
   .CLKOUT_EN   (CLKOUT_EN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pad_in     (pad_in),
   .pad_out    (pad_out),
   .pad_oe     (pad_oe),
   .pad_pu     (pad_pu),
   .dir_q      (dir_q),
   .port_q     (port_q),
   .pin_sync   (pin_sync),
   .pullup_dis (pullup_dis),
   .tx_en      (tx_en),
   .tx_data    (tx_data),
   .rx_en      (rx_en),
   .cmpa_en    (cmpa_en),
   .clkout_cfg (clkout_cfg),
   .clk_div    (clk_div)
);

// File: tb/gpio_port_ovr_test.sv
`timescale 1ns/1ps
module gpio_port_ovr_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [7:0] pad_in = 8'h00;
   logic [7:0] pad_out, pad_oe, pad_pu;
   logic       pullup_dis = 1'b0;
   logic       tx_en = 1'b0, tx_data = 1'b0, rx_en = 1'b0;
   logic       cmpa_en = 1'b0, cmpa_data = 1'b0, cmpb_en = 1'b0, cmpb_data = 1'b0;
   logic       clkout_cfg = 1'b0, clk_div = 1'b0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   gpio_port_ovr uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
      .pullup_dis(pullup_dis), .tx_en(tx_en), .tx_data(tx_data), .rx_en(rx_en),
      .cmpa_en(cmpa_en), .cmpa_data(cmpa_data), .cmpb_en(cmpb_en),
      .cmpb_data(cmpb_data), .clkout_cfg(clkout_cfg), .clk_div(clk_div)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // ctl bits: 0 tx_en 1 tx_data 2 rx_en 3 cmpa_en 4 cmpa_data
   //           5 cmpb_en 6 cmpb_data 7 clkout_cfg 8 clk_div 9 pullup_dis
   function automatic logic [23:0] model(input logic [7:0] dir, input logic [7:0] port,
                                         input logic [9:0] c);
      logic [7:0] oe, lv, pu;
      oe = dir;
      lv = port;
      if (c[5] && dir[0]) lv[0] = c[6];
      if (c[3] && dir[1]) lv[1] = c[4];
      if (c[2]) oe[2] = 1'b0;
      if (c[0]) begin oe[3] = 1'b1; lv[3] = c[1]; end
      if (c[7]) begin oe[0] = 1'b1; lv[0] = c[8]; end
      pu = ~oe & port & {8{~c[9]}};
      return {oe, oe & lv, pu};
   endfunction

   task automatic apply(input logic [9:0] c);
      {pullup_dis, clk_div, clkout_cfg, cmpb_data, cmpb_en,
       cmpa_data, cmpa_en, rx_en, tx_data, tx_en} = c;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      logic [23:0] e;
      logic [7:0] dpat [4];
      logic [7:0] ppat [4];
      dpat = '{8'hFF, 8'h00, 8'h0F, 8'hF0};
      ppat = '{8'hFF, 8'hFF, 8'h5A, 8'h00};

      // R1 / R10: during reset
      repeat (2) @(negedge clk);
      #1;
      chk("R1 reset oe", {24'd0, pad_oe}, 32'h00);
      chk("R1 reset pu", {24'd0, pad_pu}, 32'h00);
      clkout_cfg = 1'b1; clk_div = 1'b1; #1;
      chk("R10 clock in reset oe/out", {16'd0, pad_oe, pad_out}, 32'h0101);
      clk_div = 1'b0; #1;
      chk("R10 clock in reset follows clk_div", {16'd0, pad_oe, pad_out}, 32'h0100);
      clkout_cfg = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      rd(2'd1, r); chk("R1 dir after reset", {24'd0, r}, 32'h00);
      rd(2'd2, r); chk("R1 port after reset", {24'd0, r}, 32'h00);
      chk("R1 pads after reset", {8'd0, pad_oe, pad_out, pad_pu}, 32'h0);

      // R2: register access and ignored addresses
      tx_en = 1'b1; rx_en = 1'b1;
      wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
      rd(2'd1, r); chk("R2 dir readback not overridden", {24'd0, r}, 32'hA5);
      rd(2'd2, r); chk("R2 port readback", {24'd0, r}, 32'h3C);
      tx_en = 1'b0; rx_en = 1'b0;
      wr(2'd3, 8'hFF); wr(2'd0, 8'hFF);
      rd(2'd1, r); chk("R2 dir unchanged by addr 0/3 writes", {24'd0, r}, 32'hA5);
      rd(2'd2, r); chk("R2 port unchanged by addr 0/3 writes", {24'd0, r}, 32'h3C);
      rd(2'd3, r); chk("R2 unused address reads 0", {24'd0, r}, 32'h00);
      #1;
      chk("R2 pads unchanged by ignored writes", {8'd0, pad_oe, pad_out, pad_pu},
          {8'd0, 8'hA5, 8'h24, 8'h18});

      // R3: synchronizer lag
      for (int k = 0; k < 4; k++) begin
         logic [7:0] oldv, newv;
         oldv = pad_in;
         newv = 8'h5A ^ (8'h33 * k[7:0]) ^ 8'hC3;
         @(negedge clk); pad_in = newv;
         @(negedge clk); rd(2'd0, r);
         chk("R3 pin read after one edge", {24'd0, r}, {24'd0, oldv});
         @(negedge clk); rd(2'd0, r);
         chk("R3 pin read after two edges", {24'd0, r}, {24'd0, newv});
      end

      // R4 / R5: all direction values, no overrides
      for (int d = 0; d < 256; d++) begin
         logic [7:0] pv;
         pv = d[7:0] ^ 8'h96;
         wr(2'd1, d[7:0]); wr(2'd2, pv);
         #1;
         e = model(d[7:0], pv, 10'd0);
         chk("R4 R5 plain sweep", {8'd0, pad_oe, pad_out, pad_pu}, {8'd0, e});
      end

      // R12: analog input state
      wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
      wr(2'd1, 8'h00); wr(2'd2, 8'h00);
      #1;
      chk("R12 cleared pins: no drive, no pull-up", {16'd0, pad_oe, pad_pu}, 32'h0);

      // R5..R11: every control combination over four register patterns
      for (int p = 0; p < 4; p++) begin
         apply(10'd0);
         wr(2'd1, dpat[p]); wr(2'd2, ppat[p]);
         for (int m = 0; m < 1024; m++) begin
            @(negedge clk);
            apply(m[9:0]);
            #1;
            e = model(dpat[p], ppat[p], m[9:0]);
            chk("R5 R6 R7 R8 R9 R10 R11 override sweep",
                {8'd0, pad_oe, pad_out, pad_pu}, {8'd0, e});
         end
      end

      // R11: explicit clock-over-compare case on shared pin 0
      apply(10'd0);
      wr(2'd1, 8'h01); wr(2'd2, 8'h00);
      @(negedge clk);
      cmpb_en = 1'b1; cmpb_data = 1'b1; clkout_cfg = 1'b1; clk_div = 1'b0;
      #1;
      chk("R11 clock beats compare B", {31'd0, pad_out[0]}, 32'd0);
      clkout_cfg = 1'b0; #1;
      chk("R9 compare B reaches pin with dir set", {31'd0, pad_out[0]}, 32'd1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule